// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for a synchronous burst memory. The external address is captured when either of two active-low address strobes is low at a rising clock edge. After that capture, the two least significant address bits step through a four-beat burst each time the active-low advance input is low. The upper address bits stay fixed for the whole burst.

The beat order is chosen by a strap input. When the strap is low, the low bits count up by one and wrap modulo four. When the strap is at any other value, the low bits are the captured start bits XORed with a running two-bit beat count. The strap is sampled at the moment of capture, so the order of a burst cannot change while the burst is running.

Advance steps the counter whatever kind of access the memory is doing. A read whose data is never driven out therefore moves the address exactly as a normal read does. A new external address may be captured on every cycle, so bursting is optional. The memory array, data path and write control lie outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous active-low reset, `addr_o` is all zeros and the stored order is interleaved.
- R2: If `strobe_a_n` or `strobe_b_n` is low at a rising edge, then after that edge `addr_o` equals the `addr_i` value sampled at that edge.
- R3: In linear order (strap `order_lin_n` low at capture), each advance sets `addr_o[1:0]` to its previous value plus one, modulo 4.
- R4: In interleaved order (strap high at capture), `addr_o[1:0]` equals the captured start bits XOR a beat count. The beat count is 0 at capture and increases by one, modulo 4, on each advance, so start 1 gives 1,0,3,2.
- R5: A strobe and `adv_n` low in the same cycle give a capture, not an advance.
- R6: With both strobes high and `adv_n` high, `addr_o` keeps its value.
- R7: Without a strobe, `addr_o[ADDR_W-1:2]` never changes. A wrap of the low bits does not carry into the upper bits.
- R8: A fresh address can be captured on consecutive cycles, and each one is presented on the following cycle.
- R9: Changes on `order_lin_n` between captures have no effect on the running burst.
- R10: Advancing past four beats wraps the sequence back to the captured start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | External address captured on a strobe |
| strobe_a_n | input | 1 | First address strobe, active low |
| strobe_b_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin_n | input | 1 | Order strap: low selects linear order, otherwise interleaved |
| addr_o | output | ADDR_W | Current address to the array |

## Verification
The bench runs bursts from odd and even start bits in both orders and checks every beat. A design that mixed up the orders, or that added instead of XORed, gives a wrong second or third beat. It checks the linear wrap from 3 to 0; a design whose adder is wider than the burst field would carry into the upper bits and move to the wrong row. It also drives a strobe together with advance, captures on consecutive cycles, and toggles the order strap in the middle of a burst. These catch a design that lets advance win over a strobe, that drops one of the two strobes, or that follows the live strap, which would corrupt the beats after the strap changes.

// File: rtl/burst_addr_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: consumers import it before use; no parameters are held here.
package burst_addr_pkg;

    // Action the sequencer takes at the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } burst_act_e;

    // Beat order stored with each burst.
    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_ord_e;

endpackage

// File: rtl/burst_step_ctl.sv
// Module: burst_step_ctl
// Decodes the two address strobes and the advance input into one action.
// A strobe always wins over advance. Pure combinational logic.
// Assumes: all inputs are synchronous to the sequencer clock.
module burst_step_ctl
    import burst_addr_pkg::*;
(
    input  logic       strobe_a_n,
    input  logic       strobe_b_n,
    input  logic       adv_n,
    output burst_act_e act
);

    logic any_strobe;

    // Purpose: merge the two active-low strobes into one capture request.
    always_comb begin
        any_strobe = ~strobe_a_n | ~strobe_b_n;
    end

    // Purpose: priority decode: capture, then advance, else hold.
    always_comb begin
        if (any_strobe) begin
            act = ACT_LOAD;
        end else if (!adv_n) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/burst_beat_reg.sv
// Module: burst_beat_reg
// Holds the state of a burst: the upper address, the start bits, the beat
// count and the order that was sampled at capture.
// Assumes: ADDR_W > CNT_W; synchronous active-low reset.
module burst_beat_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2,
    localparam int UP_W  = ADDR_W - CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_act_e        act,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              order_lin_n,
    output logic [UP_W-1:0]   upper_q,
    output logic [CNT_W-1:0]  start_q,
    output logic [CNT_W-1:0]  beat_q,
    output burst_ord_e        ord_q
);

    burst_ord_e ord_sel;

    // Purpose: turn the strap into an order; only a solid low selects linear.
    always_comb begin
        ord_sel = (order_lin_n == 1'b0) ? ORD_LINEAR : ORD_INTERLEAVE;
    end

    // Purpose: capture the upper bits, start bits and order on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            ord_q   <= ORD_INTERLEAVE;
        end else if (act == ACT_LOAD) begin
            upper_q <= addr_i[ADDR_W-1:CNT_W];
            start_q <= addr_i[CNT_W-1:0];
            ord_q   <= ord_sel;
        end
    end

    // Purpose: clear the beat count on a load, step it modulo 2^CNT_W on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: beat_q <= '0;
                ACT_STEP: beat_q <= beat_q + 1'b1;
                default:  beat_q <= beat_q;
            endcase
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start bits and the beat count onto the low address bits in the
// order stored with the burst. Both maps are built and one is selected.
// Assumes: CNT_W >= 1; pure combinational logic.
module burst_order_map
    import burst_addr_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  burst_ord_e       ord,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] low
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] xor_low;

    // Purpose: linear order; the sum wraps inside CNT_W bits, with no carry out.
    always_comb begin
        lin_low = start + beat;
    end

    // Purpose: interleaved order, one XOR per bit.
    genvar gi;
    generate
        for (gi = 0; gi < CNT_W; gi++) begin : g_xor_bit
            assign xor_low[gi] = start[gi] ^ beat[gi];
        end
    endgenerate

    // Purpose: select the map that belongs to the stored order.
    always_comb begin
        low = (ord == ORD_LINEAR) ? lin_low : xor_low;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Burst address sequencer for a synchronous memory. It captures the address on
// either strobe, steps the low CNT_W bits on advance in linear or interleaved
// order, and keeps the upper bits fixed.
// Assumes: the order strap is sampled at capture; synchronous active-low reset.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              adv_n,
    input  logic              order_lin_n,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UP_W = ADDR_W - CNT_W;

    burst_act_e       act;
    logic [UP_W-1:0]  upper_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] beat_q;
    burst_ord_e       ord_q;
    logic [CNT_W-1:0] low_bits;

    burst_step_ctl u_ctl (
        .strobe_a_n (strobe_a_n),
        .strobe_b_n (strobe_b_n),
        .adv_n      (adv_n),
        .act        (act)
    );

    burst_beat_reg #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .addr_i      (addr_i),
        .order_lin_n (order_lin_n),
        .upper_q     (upper_q),
        .start_q     (start_q),
        .beat_q      (beat_q),
        .ord_q       (ord_q)
    );

    burst_order_map #(
        .CNT_W (CNT_W)
    ) u_map (
        .ord   (ord_q),
        .start (start_q),
        .beat  (beat_q),
        .low   (low_bits)
    );

    // Purpose: put the fixed upper bits and the mapped low bits together.
    always_comb begin
        addr_o = {upper_q, low_bits};
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Checker bound to burst_addr_gen. Its properties follow the requirements.
// Assumes: it watches the top ports plus the stored order and beat count.
module burst_addr_gen_chk
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              strobe_a_n,
    input logic              strobe_b_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_o,
    input burst_ord_e        ord_q,
    input logic [CNT_W-1:0]  beat_q
);

    logic any_strobe;
    assign any_strobe = ~strobe_a_n | ~strobe_b_n;

    // R2 and R5: a strobe captures the address, even with advance low.
    a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> addr_o == $past(addr_i));

    // R6: with no strobe and no advance the address holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && adv_n) |=> $stable(addr_o));

    // R7: the upper bits change only on a capture.
    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> $stable(addr_o[ADDR_W-1:CNT_W]));

    // R3: a linear advance adds one to the low bits, modulo 2^CNT_W.
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !adv_n && ord_q == ORD_LINEAR)
        |=> addr_o[CNT_W-1:0] == CNT_W'($past(addr_o[CNT_W-1:0]) + 1));

    // R4: an interleaved advance changes the low bits exactly as the beat count changes.
    a_r4_xor_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !adv_n && ord_q == ORD_INTERLEAVE)
        |=> (addr_o[CNT_W-1:0] ^ $past(addr_o[CNT_W-1:0])) == (beat_q ^ $past(beat_q)));

    // R9: the stored order changes only on a capture.
    a_r9_order_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> $stable(ord_q));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .strobe_a_n (strobe_a_n),
    .strobe_b_n (strobe_b_n),
    .adv_n      (adv_n),
    .addr_o     (addr_o),
    .ord_q      (ord_q),
    .beat_q     (beat_q)
);

// File: tb/burst_addr_gen_tb_top.sv
// Scoreboard bench for burst_addr_gen. The driver task applies one cycle of
// stimulus and, after the edge, pushes the expected address from its own model.
// The monitor pops each item at the next falling edge and compares it.
module burst_addr_gen_tb_top;

    localparam int ADDR_W = 20;
    localparam int CNT_W  = 2;

    typedef struct {
        logic [ADDR_W-1:0] exp;
        string             req;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              strobe_a_n = 1'b1;
    logic              strobe_b_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              order_lin_n = 1'b1;
    logic [ADDR_W-1:0] addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];
    sb_item_t cur;

    // Bench model of the burst state.
    logic [ADDR_W-1:0] m_base = '0;
    logic [CNT_W-1:0]  m_beat = '0;
    bit                m_lin  = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .strobe_a_n  (strobe_a_n),
        .strobe_b_n  (strobe_b_n),
        .adv_n       (adv_n),
        .order_lin_n (order_lin_n),
        .addr_o      (addr_o)
    );

    function automatic logic [ADDR_W-1:0] model_addr();
        logic [CNT_W-1:0] lo;
        lo = m_lin ? CNT_W'(m_base[CNT_W-1:0] + m_beat) : (m_base[CNT_W-1:0] ^ m_beat);
        return {m_base[ADDR_W-1:CNT_W], lo};
    endfunction

    task automatic check(input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: addr_o=%h expected %h", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, then the expected result is pushed after the edge.
    task automatic drive(input logic sa, input logic sb, input logic adv,
                         input logic [ADDR_W-1:0] a, input logic ordn, input string req);
        sb_item_t it;
        @(negedge clk);
        strobe_a_n  = sa;
        strobe_b_n  = sb;
        adv_n       = adv;
        addr_i      = a;
        order_lin_n = ordn;
        @(posedge clk);
        if (!sa || !sb) begin
            m_base = a;
            m_beat = '0;
            m_lin  = (ordn == 1'b0);
        end else if (!adv) begin
            m_beat = m_beat + 1'b1;
        end
        it.exp = model_addr();
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge after each pushed item.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            check(addr_o, cur.exp, cur.req);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value.
        check(addr_o, '0, "R1");
        // R1: after reset the stored order is interleaved: 0^1=1, 0^2=2.
        drive(1, 1, 0, 20'h0, 1, "R1");
        drive(1, 1, 0, 20'h0, 1, "R1");

        // R2/R3/R7/R10: strobe A, linear from start 2: 2,3,0,1 then back to 2.
        drive(0, 1, 1, 20'h12342, 0, "R2");
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 20'h0, 0, "R3_R7_R10");

        // R6: hold with no strobe and no advance.
        drive(1, 1, 1, 20'hFFFFF, 0, "R6");
        drive(1, 1, 1, 20'h00000, 1, "R6");

        // R2/R4: strobe B, interleaved from start 1: 1,0,3,2.
        drive(1, 0, 1, 20'hABCD1, 1, "R2");
        for (int i = 0; i < 3; i++) drive(1, 1, 0, 20'h0, 1, "R4");
        // R10: wrap back to the start in interleaved order.
        drive(1, 1, 0, 20'h0, 1, "R10");

        // R4: interleaved from 3: 3,2,1,0; from 2: 2,3,0,1.
        drive(0, 1, 1, 20'h55553, 1, "R4");
        for (int i = 0; i < 3; i++) drive(1, 1, 0, 20'h0, 1, "R4");
        drive(0, 0, 1, 20'h00006, 1, "R4");
        for (int i = 0; i < 3; i++) drive(1, 1, 0, 20'h0, 1, "R4");

        // R5: strobe together with advance gives a capture.
        drive(1, 1, 0, 20'h0, 1, "R5");
        drive(0, 1, 0, 20'h77771, 1, "R5");
        drive(1, 0, 0, 20'h33332, 0, "R5");

        // R8: captures on consecutive cycles.
        drive(0, 1, 1, 20'h11110, 0, "R8");
        drive(1, 0, 1, 20'h22223, 1, "R8");
        drive(0, 1, 0, 20'h44441, 0, "R8");

        // R9: linear burst from 1, strap toggled mid-burst: 1,2,3,0.
        drive(0, 1, 1, 20'h9ABC1, 0, "R9");
        drive(1, 1, 0, 20'h0, 1, "R9");
        drive(1, 1, 0, 20'h0, 0, "R9");
        drive(1, 1, 0, 20'h0, 1, "R9");
        // R7: linear wrap 3->0 from upper 0x0FFFF must not carry.
        drive(0, 1, 1, 20'h0FFFF, 0, "R7");
        drive(1, 1, 0, 20'h0, 0, "R7");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule